// File: doc/BRIEF.md
# Smart Card Host Control Interface

This block is the digital control logic that sits between a host controller and the slot of a smart card reader. The host gives it a chip select, an active-low session request, a power-down request, a reset level for the card and a supply voltage choice. The slot reports card presence and two fault flags. From these the block runs a small four-state sequencer that powers the card up and down. It also produces a card reset that follows the host once the card is powered, and a single active-low status line. The meaning of that status line depends on whether a session is in progress.

When chip select is low, the block freezes every host control it has seen. It releases the status line by dropping its output enable, and it presents the data and auxiliary host lines internally as pulled high. Several such blocks can therefore share one set of host wires. A fault during a session ends the session without any host action. The fault then stays visible on the status line until the host withdraws its session request.

Top module: `sc_host_ctrl`

## Requirements
- R1: While `cs_i` is 1, the effective host controls (session request, power down, reset level, voltage select) equal the live inputs. While `cs_i` is 0, they hold the values sampled at the last rising clock edge at which `cs_i` was 1.
- R2: `status_oe_o` is 1 exactly when `cs_i` is 1.
- R3: While `cs_i` is 0, `data_view_o`, `aux1_view_o` and `aux2_view_o` are 1. While `cs_i` is 1, they equal the corresponding host lines.
- R4: When the sequencer is idle (`seq_state_o` = 0) and no fault is latched, `status_n_o` equals `card_present_i`, so a 0 means the slot is empty.
- R5: From idle, the sequencer enters activation (`seq_state_o` = 1) at the next edge only when the effective session request is 0, a card is present, no fault is latched and the effective power down is 0. Otherwise it stays idle (0).
- R6: Activation lasts `ACT_CYCLES` cycles and is followed by active (`seq_state_o` = 2). Deactivation (`seq_state_o` = 3) lasts `DEACT_CYCLES` cycles and is followed by idle.
- R7: In activation or active, a missing card, `volt_fault_i` = 1 or `therm_fault_i` = 1 moves the sequencer to deactivation at the next edge and latches a fault. While a fault is latched, `status_n_o` is 0.
- R8: A latched fault clears only at an edge where the effective session request is 1. While it is latched, no new activation starts.
- R9: In activation or active with no fault, an effective session request of 1 moves the sequencer to deactivation at the next edge. While no fault is latched, `status_n_o` is 1 in activation, active and deactivation.
- R10: `pwr_down_o` is 1 only when the effective power down is 1 and the sequencer is idle. During a session, power down does not change the sequence.
- R11: `card_rst_o` equals the effective reset level while the sequencer is active, and is 0 in every other state.
- R12: `supply_en_o` is 1 in activation and active, and 0 in idle and deactivation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select; 0 freezes host controls |
| act_req_n_i | input | 1 | Session request, active low |
| pwrdn_i | input | 1 | Power-down request |
| rst_in_i | input | 1 | Host reset level for the card |
| vsel_i | input | 1 | Card supply voltage choice |
| host_data_i | input | 1 | Host data line |
| host_aux1_i | input | 1 | Host auxiliary line 1 |
| host_aux2_i | input | 1 | Host auxiliary line 2 |
| card_present_i | input | 1 | Card inserted in slot |
| volt_fault_i | input | 1 | Supply voltage fault |
| therm_fault_i | input | 1 | Thermal or over-current fault |
| status_n_o | output | 1 | Presence (idle) or fault (session), active low |
| status_oe_o | output | 1 | Output enable for the status line |
| card_rst_o | output | 1 | Card reset |
| supply_en_o | output | 1 | Request to power the card |
| pwr_down_o | output | 1 | Power-down granted |
| vsel_o | output | 1 | Effective voltage choice |
| seq_state_o | output | 2 | Sequencer state: 0 idle, 1 activation, 2 active, 3 deactivation |
| data_view_o | output | 1 | Internal view of the data line |
| aux1_view_o | output | 1 | Internal view of auxiliary line 1 |
| aux2_view_o | output | 1 | Internal view of auxiliary line 2 |

## Verification
The sequencer is driven through a clean session ended by the host, and through sessions ended by each fault kind in turn: voltage, thermal and card removal, hitting both activation and active. These runs separate a host-driven shutdown, which leaves the status line high, from a fault shutdown, which latches it low until the request is withdrawn. Session requests are also made with no card, with power down held and with a stale fault, and each must be refused. A deselected phase changes every live host input and shows that only the frozen values steer the sequence. A long stretch of biased random inputs, compared cycle by cycle against the reference model, then covers the mixed orderings.

// File: rtl/sc_host_pkg.sv
package sc_host_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE       = 2'd0,
        SEQ_ACTIVATING = 2'd1,
        SEQ_ACTIVE     = 2'd2,
        SEQ_DEACT      = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic act_req_n;
        logic pwrdn;
        logic rst_in;
        logic vsel;
    } host_ctl_t;

    localparam host_ctl_t HOST_CTL_RESET = '{act_req_n: 1'b1, pwrdn: 1'b0,
                                             rst_in: 1'b0, vsel: 1'b0};

endpackage

// File: rtl/sc_host_latch.sv
module sc_host_latch
    import sc_host_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      cs_i,
    input  host_ctl_t live_i,
    input  logic      data_i,
    input  logic      aux1_i,
    input  logic      aux2_i,
    output host_ctl_t eff_o,
    output logic      data_o,
    output logic      aux1_o,
    output logic      aux2_o
);

    typedef struct packed {
        host_ctl_t hold;
    } latch_reg_t;

    latch_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cs_i) begin
            r_d.hold = live_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.hold <= HOST_CTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // Transparent while selected, frozen while deselected.
    assign eff_o  = cs_i ? live_i : r_q.hold;
    assign data_o = cs_i ? data_i : 1'b1;
    assign aux1_o = cs_i ? aux1_i : 1'b1;
    assign aux2_o = cs_i ? aux2_i : 1'b1;

    p_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_i ##1 !cs_i) |-> $stable(eff_o));

endmodule

// File: rtl/sc_fault_mon.sv
module sc_fault_mon (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_session_i,
    input  logic card_present_i,
    input  logic volt_fault_i,
    input  logic therm_fault_i,
    input  logic act_req_n_i,
    output logic fault_cond_o,
    output logic fault_o
);

    typedef struct packed {
        logic fault;
    } fault_reg_t;

    fault_reg_t r_d, r_q;
    logic       cond;

    assign cond = in_session_i & (~card_present_i | volt_fault_i | therm_fault_i);

    always_comb begin
        r_d = r_q;
        if (cond) begin
            r_d.fault = 1'b1;
        end else if (act_req_n_i) begin
            r_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.fault <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fault_cond_o = cond;
    assign fault_o      = r_q.fault;

    p_fault_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_session_i && volt_fault_i) |=> fault_o);

    p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && !act_req_n_i) |=> fault_o);

endmodule

// File: rtl/sc_seq.sv
module sc_seq
    import sc_host_pkg::*;
#(
    parameter int unsigned ACT_CYCLES   = 4,
    parameter int unsigned DEACT_CYCLES = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       act_req_n_i,
    input  logic       pwrdn_i,
    input  logic       card_present_i,
    input  logic       fault_latched_i,
    input  logic       fault_cond_i,
    output seq_state_e state_o,
    output logic       in_session_o,
    output logic       rst_en_o,
    output logic       supply_en_o,
    output logic       pwr_down_o
);

    localparam int unsigned MAXC = (ACT_CYCLES > DEACT_CYCLES) ? ACT_CYCLES : DEACT_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ACT_LAST   = CW'(ACT_CYCLES - 1);
    localparam logic [CW-1:0] DEACT_LAST = CW'(DEACT_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
    } seq_reg_t;

    seq_reg_t r_d, r_q;
    logic     start;

    assign start = ~act_req_n_i & card_present_i & ~fault_latched_i & ~pwrdn_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_IDLE: begin
                r_d.cnt = '0;
                if (start) begin
                    r_d.state = SEQ_ACTIVATING;
                end
            end
            SEQ_ACTIVATING: begin
                if (fault_cond_i || act_req_n_i) begin
                    r_d.state = SEQ_DEACT;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == ACT_LAST) begin
                    r_d.state = SEQ_ACTIVE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SEQ_ACTIVE: begin
                r_d.cnt = '0;
                if (fault_cond_i || act_req_n_i) begin
                    r_d.state = SEQ_DEACT;
                end
            end
            SEQ_DEACT: begin
                if (r_q.cnt == DEACT_LAST) begin
                    r_d.state = SEQ_IDLE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= SEQ_IDLE;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o      = r_q.state;
    assign in_session_o = (r_q.state == SEQ_ACTIVATING) || (r_q.state == SEQ_ACTIVE);
    assign supply_en_o  = in_session_o;
    assign rst_en_o     = (r_q.state == SEQ_ACTIVE);
    assign pwr_down_o   = pwrdn_i && (r_q.state == SEQ_IDLE);

    p_start_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == SEQ_IDLE && (act_req_n_i || !card_present_i || fault_latched_i || pwrdn_i))
        |=> (r_q.state == SEQ_IDLE));

    p_no_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == SEQ_IDLE) |=> (r_q.state == SEQ_IDLE || r_q.state == SEQ_ACTIVATING));

    p_fault_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_cond_i |=> (r_q.state == SEQ_DEACT));

    p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_session_o && act_req_n_i) |=> (r_q.state == SEQ_DEACT));

    p_pd_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == SEQ_ACTIVE && !act_req_n_i && !fault_cond_i) |=> (r_q.state == SEQ_ACTIVE));

endmodule

// File: rtl/sc_host_ctrl.sv
module sc_host_ctrl
    import sc_host_pkg::*;
#(
    parameter int unsigned ACT_CYCLES   = 4,
    parameter int unsigned DEACT_CYCLES = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cs_i,
    input  logic       act_req_n_i,
    input  logic       pwrdn_i,
    input  logic       rst_in_i,
    input  logic       vsel_i,
    input  logic       host_data_i,
    input  logic       host_aux1_i,
    input  logic       host_aux2_i,
    input  logic       card_present_i,
    input  logic       volt_fault_i,
    input  logic       therm_fault_i,
    output logic       status_n_o,
    output logic       status_oe_o,
    output logic       card_rst_o,
    output logic       supply_en_o,
    output logic       pwr_down_o,
    output logic       vsel_o,
    output logic [1:0] seq_state_o,
    output logic       data_view_o,
    output logic       aux1_view_o,
    output logic       aux2_view_o
);

    host_ctl_t  live, eff;
    seq_state_e state;
    logic       in_session, rst_en, fault_cond, fault_q, session_view;

    assign live = '{act_req_n: act_req_n_i, pwrdn: pwrdn_i, rst_in: rst_in_i, vsel: vsel_i};

    sc_host_latch u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cs_i   (cs_i),
        .live_i (live),
        .data_i (host_data_i),
        .aux1_i (host_aux1_i),
        .aux2_i (host_aux2_i),
        .eff_o  (eff),
        .data_o (data_view_o),
        .aux1_o (aux1_view_o),
        .aux2_o (aux2_view_o)
    );

    sc_fault_mon u_fault (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .in_session_i   (in_session),
        .card_present_i (card_present_i),
        .volt_fault_i   (volt_fault_i),
        .therm_fault_i  (therm_fault_i),
        .act_req_n_i    (eff.act_req_n),
        .fault_cond_o   (fault_cond),
        .fault_o        (fault_q)
    );

    sc_seq #(
        .ACT_CYCLES   (ACT_CYCLES),
        .DEACT_CYCLES (DEACT_CYCLES)
    ) u_seq (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .act_req_n_i     (eff.act_req_n),
        .pwrdn_i         (eff.pwrdn),
        .card_present_i  (card_present_i),
        .fault_latched_i (fault_q),
        .fault_cond_i    (fault_cond),
        .state_o         (state),
        .in_session_o    (in_session),
        .rst_en_o        (rst_en),
        .supply_en_o     (supply_en_o),
        .pwr_down_o      (pwr_down_o)
    );

    // Status meaning switches from presence to fault once a session exists.
    assign session_view = (state != SEQ_IDLE) || fault_q;
    assign status_n_o   = session_view ? ~fault_q : card_present_i;
    assign status_oe_o  = cs_i;
    assign card_rst_o   = rst_en & eff.rst_in;
    assign vsel_o       = eff.vsel;
    assign seq_state_o  = state;

    p_status_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_q |-> !status_n_o);

    p_rst_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_state_o != 2'd2) |-> !card_rst_o);

endmodule

// File: tb/test_sc_host_ctrl.sv
`timescale 1ns/1ps
module test_sc_host_ctrl;

    localparam int ACT   = 4;
    localparam int DEACT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b1, act_n = 1'b1, pwrdn = 1'b0, rstin = 1'b0, vsel = 1'b0;
    logic d = 1'b0, a1 = 1'b0, a2 = 1'b0, present = 1'b0, vf = 1'b0, tf = 1'b0;
    logic status_n, status_oe, card_rst, supply_en, pwr_down, vsel_o;
    logic [1:0] st;
    logic dv, a1v, a2v;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    int m_state = 0, m_cnt = 0, m_fault = 0;
    int h_act = 1, h_pd = 0, h_rst = 0, h_vsel = 0;

    always #2.5 clk = ~clk;

    sc_host_ctrl #(.ACT_CYCLES(ACT), .DEACT_CYCLES(DEACT)) i_sc_host_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .act_req_n_i(act_n), .pwrdn_i(pwrdn),
        .rst_in_i(rstin), .vsel_i(vsel), .host_data_i(d), .host_aux1_i(a1),
        .host_aux2_i(a2), .card_present_i(present), .volt_fault_i(vf),
        .therm_fault_i(tf), .status_n_o(status_n), .status_oe_o(status_oe),
        .card_rst_o(card_rst), .supply_en_o(supply_en), .pwr_down_o(pwr_down),
        .vsel_o(vsel_o), .seq_state_o(st), .data_view_o(dv), .aux1_view_o(a1v),
        .aux2_view_o(a2v)
    );

    function automatic int e_act();  return cs ? int'(act_n) : h_act;  endfunction
    function automatic int e_pd();   return cs ? int'(pwrdn) : h_pd;   endfunction
    function automatic int e_rst();  return cs ? int'(rstin) : h_rst;  endfunction
    function automatic int e_vsel(); return cs ? int'(vsel) : h_vsel;  endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int sess;
        sess = (m_state != 0 || m_fault != 0) ? 1 : 0;
        chk("R2 status_oe", int'(status_oe), int'(cs));
        chk("R3 data_view", int'(dv), cs ? int'(d) : 1);
        chk("R3 aux1_view", int'(a1v), cs ? int'(a1) : 1);
        chk("R3 aux2_view", int'(a2v), cs ? int'(a2) : 1);
        chk("R1 vsel_o", int'(vsel_o), e_vsel());
        chk("R4/R7/R9 status_n", int'(status_n), sess ? (m_fault ? 0 : 1) : int'(present));
        chk("R5/R6 seq_state", int'(st), m_state);
        chk("R10 pwr_down", int'(pwr_down), (e_pd() != 0 && m_state == 0) ? 1 : 0);
        chk("R11 card_rst", int'(card_rst), (m_state == 2) ? e_rst() : 0);
        chk("R12 supply_en", int'(supply_en), (m_state == 1 || m_state == 2) ? 1 : 0);
    endtask

    task automatic model_edge();
        int cond, a, ns, nc, nf;
        a = e_act();
        cond = ((m_state == 1 || m_state == 2) && (!present || vf || tf)) ? 1 : 0;
        nf = cond ? 1 : (a ? 0 : m_fault);
        ns = m_state; nc = 0;
        case (m_state)
            0: if (!a && present && !m_fault && !e_pd()) ns = 1;
            1: if (cond || a) ns = 3;
               else if (m_cnt == ACT - 1) ns = 2;
               else nc = m_cnt + 1;
            2: if (cond || a) ns = 3;
            default: if (m_cnt == DEACT - 1) ns = 0; else nc = m_cnt + 1;
        endcase
        if (cs) begin
            h_act = act_n; h_pd = pwrdn; h_rst = rstin; h_vsel = vsel;
        end
        m_state = ns; m_cnt = nc; m_fault = nf;
    endtask

    // Inputs are set at a falling edge; compare, take the rising edge, return at the next falling edge.
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state
        chk("R5 reset state idle", int'(st), 0);
        chk("R12 reset supply off", int'(supply_en), 0);
        chk("R11 reset card_rst low", int'(card_rst), 0);
        rst_n = 1'b1;

        // R4: presence reporting while idle
        present = 0; ticks(2);
        present = 1; ticks(2);
        // R5: request with no card is refused
        present = 0; act_n = 0; ticks(3);
        chk("R5 no start without card", int'(st), 0);
        act_n = 1; present = 1; ticks(1);
        // R10: power down blocks activation while idle
        pwrdn = 1; act_n = 0; ticks(3);
        chk("R10 no start in power down", int'(st), 0);
        pwrdn = 0; ticks(1);
        // R6/R11: normal activation, reset follows host, power down ignored
        ticks(ACT + 1);
        chk("R6 active after activation", int'(st), 2);
        rstin = 1; ticks(2);
        pwrdn = 1; ticks(2);
        chk("R10 power down ignored in session", int'(st), 2);
        rstin = 0; pwrdn = 0; ticks(1);
        // R9: host release
        act_n = 1; ticks(DEACT + 2);
        chk("R9 back to idle", int'(st), 0);
        // R7/R8: voltage fault during active
        act_n = 0; ticks(ACT + 2);
        vf = 1; ticks(1); vf = 0; ticks(DEACT + 3);
        chk("R8 no restart while latched", int'(st), 0);
        chk("R7 status low while latched", int'(status_n), 0);
        act_n = 1; ticks(2);
        // thermal fault during activation
        act_n = 0; ticks(2);
        tf = 1; ticks(1); tf = 0; act_n = 1; ticks(DEACT + 2);
        // card removal during active
        act_n = 0; ticks(ACT + 2);
        present = 0; ticks(2); present = 1; ticks(DEACT + 2);
        act_n = 1; ticks(2);
        // R1/R2/R3: deselect freezes controls during a session
        act_n = 0; rstin = 1; vsel = 1; ticks(ACT + 2);
        cs = 0; ticks(1);
        act_n = 1; rstin = 0; vsel = 0; pwrdn = 1; d = 0; a1 = 0; a2 = 0; ticks(4);
        chk("R1 session held while frozen", int'(st), 2);
        chk("R1 reset held while frozen", int'(card_rst), 1);
        cs = 1; ticks(DEACT + 3);
        pwrdn = 0; ticks(1);

        // Mixed random phase
        for (int i = 0; i < 3000; i++) begin
            cs      = ($urandom_range(0, 9) != 0);
            act_n   = ($urandom_range(0, 5) == 0);
            pwrdn   = ($urandom_range(0, 9) == 0);
            rstin   = $urandom_range(0, 1);
            vsel    = $urandom_range(0, 1);
            d       = $urandom_range(0, 1);
            a1      = $urandom_range(0, 1);
            a2      = $urandom_range(0, 1);
            present = ($urandom_range(0, 19) != 0);
            vf      = ($urandom_range(0, 39) == 0);
            tf      = ($urandom_range(0, 39) == 0);
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule